// File: doc/BRIEF.md
# Gated Page-Three Expansion I/O Port

This block is an add-on peripheral for a 6502-style home computer bus. The system logic already raises a select line for every access to the 256-byte I/O page at 0x0300–0x03FF. The port uses that line instead of decoding the upper address byte itself. It compares only the upper nibble of the low address byte to claim a 16-byte window at a configurable base inside the page. The built-in interface adapter on the board answers everywhere in the page, because it does no decoding of its own. So whenever the port claims an access, it raises an override output that silences the adapter.

The window holds four 8-bit read/write registers at offsets 0 to 3. The other twelve offsets read as zero and ignore writes. The CPU keeps the address valid for almost the whole bus cycle. During the low phase of the CPU clock, the video logic uses the shared data bus to read DRAM. For that reason the port enables its data driver only while the phase clock is high, the access is claimed and it is a read. Writes are committed once per bus cycle, on the falling edge of the phase clock, as seen through a synchronizer in the fast system clock domain.

Top module: `exp_io_port`

## Requirements
- R1: After reset all four registers read as 0x00, and `data_oe` and `adapter_off` are low while no access is claimed.
- R2: `adapter_off` is high exactly when `page_sel` is high and `addr_lo[7:4]` equals `WIN_BASE[7:4]` (default base 0x60, so addresses 0x60–0x6F). This holds in both phases of the phase clock and for reads and writes alike.
- R3: When `page_sel` falls during a claimed access, `adapter_off` and `data_oe` drop at once, with no clock edge in between.
- R4: `data_oe` is high only when the access is claimed, `rd_nwr` is 1 (1 = read, 0 = write) and `phi2` is high. It is never high while `phi2` is low, and never high during a write.
- R5: An access outside the window, or any access with `page_sel` low, asserts neither `adapter_off` nor `data_oe` and changes no register.
- R6: During a claimed read, `data_out` carries register `addr_lo[1:0]` for window offsets 0–3 and 0x00 for offsets 4–15.
- R7: A claimed write (`rd_nwr` = 0) to offset 0–3 stores the `data_in` value present while `phi2` was high. The commit follows the falling edge of `phi2`, within five `clk` cycles. A write to offsets 4–15 changes no register.
- R8: A write commits exactly once per bus cycle. A new `data_in` value that appears after `phi2` has fallen, with the address still claimed and `rd_nwr` still 0, does not replace the stored value. Bus inputs must stay stable for three `clk` cycles after `phi2` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock used to sample the phase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| page_sel | input | 1 | High when the system logic flags an I/O-page access |
| addr_lo | input | 8 | Low byte of the CPU address |
| rd_nwr | input | 1 | Bus direction, 1 = read, 0 = write |
| phi2 | input | 1 | CPU phase clock, high during the CPU half of the cycle |
| data_in | input | 8 | Data bus value seen by the port |
| data_out | output | 8 | Read data to be driven onto the bus |
| data_oe | output | 1 | Tri-state enable for `data_out` |
| adapter_off | output | 1 | Override that silences the on-board interface adapter |

## Verification
Two functions can land in the same `clk` cycle. One is the delayed, synchronized commit of a write. The other is the combinational decode of the next claimed access, which asserts the override and selects read data from the same register. The bench provokes this by writing a register and reading it back in the very next bus cycle. The read must return the new value, and it must not return the inverted value the bench puts on `data_in` after `phi2` falls. A second overlap arises when `page_sel` is pulled away mid-phase during a read. There the override and the drive enable must both collapse in the same sample.

// File: rtl/exp_io_pkg.sv
package exp_io_pkg;

  // True when the address falls in the aligned window starting at base.
  function automatic logic win_hit(input logic [7:0] a, input logic [7:0] base,
                                   input int unsigned win_bits);
    return (a >> win_bits) == (base >> win_bits);
  endfunction

  // True when a window offset lands on a backed register.
  function automatic logic is_backed(input logic [7:0] off, input int unsigned nregs);
    return off < nregs[7:0];
  endfunction

endpackage

// File: rtl/exp_io_decode.sv
module exp_io_decode #(
  parameter logic [7:0] WIN_BASE = 8'h60,
  parameter int WIN_BITS = 4
) (
  input  logic                page_sel,
  input  logic [7:0]          addr_lo,
  output logic                hit,
  output logic [WIN_BITS-1:0] off
);
  assign hit = page_sel && exp_io_pkg::win_hit(addr_lo, WIN_BASE, WIN_BITS);
  assign off = addr_lo[WIN_BITS-1:0];
endmodule

// File: rtl/exp_io_wrcap.sv
module exp_io_wrcap #(
  parameter int DATA_W = 8,
  parameter int OFF_W  = 4,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi2,
  input  logic              wr_req,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] data_in,
  output logic              phi_seen,
  output logic              commit,
  output logic [OFF_W-1:0]  commit_off,
  output logic [DATA_W-1:0] commit_data
);
  logic              phi_q [SYNC];
  logic              req_q [SYNC];
  logic [OFF_W-1:0]  off_q [SYNC];
  logic [DATA_W-1:0] dat_q [SYNC];

  // Phase clock and bus snapshot travel through the same number of stages.
  for (genvar s = 0; s < SYNC; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          phi_q[0] <= 1'b0; req_q[0] <= 1'b0;
          off_q[0] <= '0;   dat_q[0] <= '0;
        end else begin
          phi_q[0] <= phi2; req_q[0] <= wr_req;
          off_q[0] <= off;  dat_q[0] <= data_in;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          phi_q[s] <= 1'b0; req_q[s] <= 1'b0;
          off_q[s] <= '0;   dat_q[s] <= '0;
        end else begin
          phi_q[s] <= phi_q[s-1]; req_q[s] <= req_q[s-1];
          off_q[s] <= off_q[s-1]; dat_q[s] <= dat_q[s-1];
        end
      end
    end
  end

  assign phi_seen = phi_q[SYNC-1];

  logic              phi_prev;
  logic              held_req;
  logic [OFF_W-1:0]  held_off;
  logic [DATA_W-1:0] held_dat;
  logic              phi_fall;

  assign phi_fall = phi_prev && !phi_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phi_prev    <= 1'b0;
      held_req    <= 1'b0;
      held_off    <= '0;
      held_dat    <= '0;
      commit      <= 1'b0;
      commit_off  <= '0;
      commit_data <= '0;
    end else begin
      phi_prev <= phi_seen;
      if (phi_seen) begin
        held_req <= req_q[SYNC-1];
        held_off <= off_q[SYNC-1];
        held_dat <= dat_q[SYNC-1];
      end
      commit      <= phi_fall && held_req;
      commit_off  <= held_off;
      commit_data <= held_dat;
    end
  end
endmodule

// File: rtl/exp_io_regfile.sv
module exp_io_regfile #(
  parameter int DATA_W = 8,
  parameter int OFF_W  = 4,
  parameter int NREGS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data
);
  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic [DATA_W-1:0] regs [NREGS];
  logic [7:0] wr_off8, rd_off8;

  assign wr_off8 = 8'(wr_off);
  assign rd_off8 = 8'(rd_off);

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs[r] <= '0;
      else if (wr_en && exp_io_pkg::is_backed(wr_off8, NREGS) &&
               wr_off[IDX_W-1:0] == IDX_W'(r))
        regs[r] <= wr_data;
    end
  end

  assign rd_data = exp_io_pkg::is_backed(rd_off8, NREGS) ? regs[rd_off[IDX_W-1:0]] : '0;
endmodule

// File: rtl/exp_io_port.sv
module exp_io_port #(
  parameter logic [7:0] WIN_BASE = 8'h60,
  parameter int WIN_BITS = 4,
  parameter int NREGS    = 4,
  parameter int SYNC     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       page_sel,
  input  logic [7:0] addr_lo,
  input  logic       rd_nwr,
  input  logic       phi2,
  input  logic [7:0] data_in,
  output logic [7:0] data_out,
  output logic       data_oe,
  output logic       adapter_off
);
  localparam int DATA_W = 8;

  // Named internal events for the checker.
  logic                claim;
  logic [WIN_BITS-1:0] win_off;
  logic                phi_seen;
  logic                wr_commit;
  logic [WIN_BITS-1:0] wr_off;
  logic [DATA_W-1:0]   wr_data;

  exp_io_decode #(.WIN_BASE(WIN_BASE), .WIN_BITS(WIN_BITS)) u_dec (
    .page_sel(page_sel), .addr_lo(addr_lo), .hit(claim), .off(win_off)
  );

  exp_io_wrcap #(.DATA_W(DATA_W), .OFF_W(WIN_BITS), .SYNC(SYNC)) u_cap (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .wr_req(claim && !rd_nwr),
    .off(win_off), .data_in(data_in), .phi_seen(phi_seen),
    .commit(wr_commit), .commit_off(wr_off), .commit_data(wr_data)
  );

  exp_io_regfile #(.DATA_W(DATA_W), .OFF_W(WIN_BITS), .NREGS(NREGS)) u_rf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_commit), .wr_off(wr_off),
    .wr_data(wr_data), .rd_off(win_off), .rd_data(data_out)
  );

  assign adapter_off = claim;
  assign data_oe     = claim && rd_nwr && phi2;
endmodule

// File: rtl/exp_io_port_chk.sv
module exp_io_port_chk #(
  parameter logic [7:0] WIN_BASE = 8'h60,
  parameter int WIN_BITS = 4,
  parameter int NREGS    = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       page_sel,
  input logic [7:0] addr_lo,
  input logic       rd_nwr,
  input logic       phi2,
  input logic [7:0] data_out,
  input logic       data_oe,
  input logic       adapter_off,
  input logic       phi_seen,
  input logic       wr_commit
);
  localparam logic [7:0] UPPER_MASK = 8'hFF << WIN_BITS;
  localparam logic [7:0] LOWER_MASK = ~UPPER_MASK;

  logic in_win;
  assign in_win = (addr_lo & UPPER_MASK) == (WIN_BASE & UPPER_MASK);

  assert_oe_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (phi2 && rd_nwr && adapter_off));

  assert_drop_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !page_sel |-> (!adapter_off && !data_oe));

  assert_outside_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_win |-> (!adapter_off && !data_oe));

  assert_claim_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (page_sel && in_win) |-> adapter_off);

  assert_zero_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && (addr_lo & LOWER_MASK) >= 8'(NREGS)) |-> (data_out == 8'h00));

  assert_single_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit);

  assert_commit_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> !phi_seen);
endmodule

bind exp_io_port exp_io_port_chk #(.WIN_BASE(WIN_BASE), .WIN_BITS(WIN_BITS), .NREGS(NREGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .page_sel(page_sel), .addr_lo(addr_lo),
  .rd_nwr(rd_nwr), .phi2(phi2), .data_out(data_out), .data_oe(data_oe),
  .adapter_off(adapter_off), .phi_seen(phi_seen), .wr_commit(wr_commit)
);

// File: tb/exp_io_port_test.sv
module exp_io_port_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       page_sel = 1'b0;
  logic [7:0] addr_lo = 8'h00;
  logic       rd_nwr = 1'b1;
  logic       phi2 = 1'b0;
  logic [7:0] data_in = 8'h00;
  logic [7:0] data_out;
  logic       data_oe;
  logic       adapter_off;

  int checks = 0;
  int errors = 0;
  int oe_bad = 0;
  bit done = 1'b0;
  logic [7:0] model [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  exp_io_port uut (
    .clk(clk), .rst_n(rst_n), .page_sel(page_sel), .addr_lo(addr_lo),
    .rd_nwr(rd_nwr), .phi2(phi2), .data_in(data_in), .data_out(data_out),
    .data_oe(data_oe), .adapter_off(adapter_off)
  );

  // R4 monitor: drive enable must never coincide with a low phase.
  always @(negedge clk) begin
    #2;
    if (rst_n && data_oe && !phi2) oe_bad++;
  end

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // One full bus cycle; samples outputs mid high phase.
  task automatic bus_cycle(input logic sel, input logic [7:0] a, input logic rd,
                           input logic [7:0] wd, output logic [7:0] rdat,
                           output logic oe_s, output logic ovr_s);
    @(negedge clk);
    page_sel = sel; addr_lo = a; rd_nwr = rd; data_in = wd; phi2 = 1'b0;
    repeat (2) @(negedge clk);
    phi2 = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    rdat = data_out; oe_s = data_oe; ovr_s = adapter_off;
    repeat (2) @(negedge clk);
    phi2 = 1'b0;
    repeat (4) @(negedge clk);
    data_in = ~wd;          // late change, still claimed and writing (R8)
    repeat (3) @(negedge clk);
    page_sel = 1'b0; data_in = 8'h00; rd_nwr = 1'b1;
  endtask

  function automatic logic claimed(input logic sel, input logic [7:0] a);
    return sel && (a[7:4] == 4'h6);
  endfunction

  function automatic logic [7:0] expect_rd(input logic [7:0] a);
    return (a[3:0] < 4) ? model[a[1:0]] : 8'h00;
  endfunction

  task automatic do_write(input string req, input logic sel, input logic [7:0] a,
                          input logic [7:0] wd);
    logic [7:0] r; logic oe, ov;
    bus_cycle(sel, a, 1'b0, wd, r, oe, ov);
    chk1({req, " write: no drive (R4)"}, oe, 1'b0);
    chk1({req, " write: override (R2)"}, ov, claimed(sel, a));
    if (claimed(sel, a) && a[3:0] < 4) model[a[1:0]] = wd;
  endtask

  task automatic do_read(input string req, input logic sel, input logic [7:0] a);
    logic [7:0] r; logic oe, ov;
    bus_cycle(sel, a, 1'b1, 8'h00, r, oe, ov);
    chk1({req, " read: drive enable (R4)"}, oe, claimed(sel, a));
    chk1({req, " read: override (R2)"}, ov, claimed(sel, a));
    if (claimed(sel, a)) chk8({req, " read data"}, r, expect_rd(a));
  endtask

  task automatic t_reset;
    chk1("R1 oe after reset", data_oe, 1'b0);
    chk1("R1 override after reset", adapter_off, 1'b0);
    for (int i = 0; i < 4; i++) do_read("R1 reset value", 1'b1, 8'h60 + 8'(i));
  endtask

  task automatic t_write_read;
    do_write("R7", 1'b1, 8'h60, 8'hA5);
    do_write("R7", 1'b1, 8'h61, 8'h3C);
    do_write("R7", 1'b1, 8'h62, 8'hFF);
    do_write("R7", 1'b1, 8'h63, 8'h01);
    for (int i = 0; i < 4; i++) do_read("R6 R8 register", 1'b1, 8'h60 + 8'(i));
  endtask

  task automatic t_zero_offsets;
    do_read("R6 unbacked", 1'b1, 8'h64);
    do_read("R6 unbacked", 1'b1, 8'h6F);
    do_write("R7 unbacked ignored", 1'b1, 8'h65, 8'h5A);
    do_read("R7 after unbacked write", 1'b1, 8'h61);
    do_read("R7 unbacked stays zero", 1'b1, 8'h65);
  endtask

  task automatic t_outside;
    do_read("R5 outside", 1'b1, 8'h70);
    do_read("R5 outside", 1'b1, 8'h5F);
    do_write("R5 outside", 1'b1, 8'h52, 8'h77);
    do_write("R5 no page", 1'b0, 8'h63, 8'h99);
    do_read("R5 register kept", 1'b1, 8'h62);
    do_read("R5 register kept", 1'b1, 8'h63);
  endtask

  task automatic t_low_phase;
    @(negedge clk);
    page_sel = 1'b1; addr_lo = 8'h60; rd_nwr = 1'b1; phi2 = 1'b0;
    repeat (2) @(negedge clk);
    #2;
    chk1("R4 low phase no drive", data_oe, 1'b0);
    chk1("R2 low phase override", adapter_off, 1'b1);
    @(negedge clk);
    phi2 = 1'b1;
    repeat (2) @(negedge clk);
    #2;
    chk1("R4 high phase drive", data_oe, 1'b1);
    page_sel = 1'b0;
    #1;
    chk1("R3 override drops", adapter_off, 1'b0);
    chk1("R3 drive drops", data_oe, 1'b0);
    repeat (2) @(negedge clk);
    phi2 = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_back_to_back;
    do_write("R8 back-to-back", 1'b1, 8'h62, 8'h4E);
    do_read("R8 back-to-back", 1'b1, 8'h62);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #2;
    t_reset;
    t_write_read;
    t_zero_offsets;
    t_outside;
    t_low_phase;
    t_back_to_back;
    checks++;
    if (oe_bad != 0) begin
      errors++;
      $display("FAIL R4 drive during low phase actual=%0d expected=0", oe_bad);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule